// File: doc/BRIEF.md
# Serial Flash Write-Protection Gate

This block decides whether each instruction that may change a 64-sector serial NOR flash is allowed to proceed. The serial front end decodes each instruction and presents it here in one cycle when chip select rises: a three-bit instruction class, the 24-bit address, the number of serial clock edges counted while selected, and the first data byte. The gate also watches the write-protect pin, a deep power-down flag and a completion pulse from the operation engine. It owns the write-enable latch and the writable status bits: a three-bit protection level and a status-lock bit.

For every control instruction it answers with a one-cycle accept or reject pulse. Accepted program, erase and status-write instructions keep the gate busy until the engine reports completion. Rejected instructions change nothing.

The controller is a three-state machine:
- `ST_BOOT` is the power-up lockout. It moves to `ST_IDLE` when the lockout timer expires.
- `ST_IDLE` evaluates instructions. It moves to `ST_BUSY` when a program, erase or status write is granted.
- `ST_BUSY` waits for the operation to finish. It returns to `ST_IDLE` on the completion pulse.

Top module: `flash_wr_guard`

## Requirements
- R1: After reset the latch, protection level and lock bit are 0. For POWERUP_CYCLES cycles every control instruction is rejected and the latch stays 0.
- R2: Set-latch (class 1) and clear-latch (class 2) are accepted in idle regardless of the edge count. Class 1 sets the latch and class 2 clears it.
- R3: Status write (3), page program (4), sector erase (5) and bulk erase (6) are rejected when the latch is clear.
- R4: Classes 3 to 6 are rejected unless the low three bits of the edge count are zero.
- R5: The sector is address bits [21:16]. Protection level L protects nothing when L=0 and the top 64>>(7-L) sectors otherwise. Program or sector erase into a protected sector is rejected.
- R6: Bulk erase is rejected unless the protection level is 0.
- R7: A status write is rejected while the lock bit is 1 and the write-protect pin is low.
- R8: While deep power-down is high, every control instruction is rejected.
- R9: An accepted class 3 to 6 instruction makes the gate busy, and every control instruction is rejected while busy. The completion pulse ends busy and clears the latch. A status write loads the level from data[4:2] and the lock bit from data[7] at completion.
- R10: A rejected instruction leaves the latch, level and lock bit unchanged.
- R11: Accept or reject pulses for one cycle, in the cycle after the instruction is presented. Classes 0 (none) and 7 (read) produce neither pulse.
- R12: A completion pulse while not busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cmd_valid | input | 1 | Decoded instruction present, one cycle |
| cmd_op | input | 3 | Instruction class (R11 encoding) |
| cmd_addr | input | 24 | Instruction address |
| cmd_edges | input | 16 | Serial clock edges counted while selected |
| cmd_data | input | 8 | First data byte |
| wp_n | input | 1 | Write-protect pin, active low |
| dpd | input | 1 | Deep power-down in effect |
| op_done | input | 1 | Operation engine completion pulse |
| cmd_accept | output | 1 | Instruction granted |
| cmd_reject | output | 1 | Instruction refused |
| wel | output | 1 | Write-enable latch |
| bp | output | 3 | Protection level |
| srwd | output | 1 | Status-lock bit |

## Verification
The completion pulse and a new instruction can arrive in the same cycle while the gate is busy. The bench drives both on one clock edge. It expects the instruction to be judged against the busy state, so it is rejected. It then expects the latch to read 0 after that edge, which shows that the completion took effect. A further set-latch instruction must then be accepted, which confirms the gate has returned to idle.

// File: rtl/flash_wr_guard_pkg.sv
package flash_wr_guard_pkg;
    typedef enum logic [2:0] {
        OPC_NONE = 3'd0,
        OPC_WREN = 3'd1,
        OPC_WRDI = 3'd2,
        OPC_WRSR = 3'd3,
        OPC_PP   = 3'd4,
        OPC_SE   = 3'd5,
        OPC_BE   = 3'd6,
        OPC_READ = 3'd7
    } opc_e;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_IDLE = 2'd1,
        ST_BUSY = 2'd2
    } gate_st_e;
endpackage

// File: rtl/fwg_boot_timer.sv
module fwg_boot_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign ready = (cnt_q == '0);

    // R1: once the lockout has expired it never re-arms
    assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
endmodule

// File: rtl/fwg_sector_map.sv
module fwg_sector_map #(
    parameter int SECTOR_BITS = 6
) (
    input  logic [2:0]             level,
    input  logic [SECTOR_BITS-1:0] sector,
    output logic                   locked
);
    localparam int SW = SECTOR_BITS + 1;
    localparam logic [SW-1:0] NUM_SECT = SW'(1 << SECTOR_BITS);

    logic [SW-1:0] span;
    logic [SW-1:0] first_locked;

    always_comb begin
        if (level == 3'd0)
            span = '0;
        else
            span = NUM_SECT >> (3'd7 - level);
        first_locked = NUM_SECT - span;
        locked = ({1'b0, sector} >= first_locked);
    end

    // R5: the highest level covers the whole array, level 0 covers nothing
    always_comb begin
        if (level == 3'd7) assert_full_cover_R5: assert (locked);
        if (level == 3'd0) assert_no_cover_R5: assert (!locked);
    end
endmodule

// File: rtl/fwg_cmd_fsm.sv
module fwg_cmd_fsm
    import flash_wr_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boot_ready,
    input  logic       cmd_valid,
    input  opc_e       op,
    input  logic [2:0] edges_lo,
    input  logic [7:0] data,
    input  logic       sector_locked,
    input  logic       wp_n,
    input  logic       dpd,
    input  logic       op_done,
    output logic       accept_q,
    output logic       reject_q,
    output logic       wel_q,
    output logic [2:0] bp_q,
    output logic       srwd_q
);
    gate_st_e   state_q, state_d;
    logic       is_mod, is_latch, is_ctrl;
    logic       bytes_ok, guard_ok, grant;
    logic       pend_wrsr_q;
    logic [2:0] pend_bp_q;
    logic       pend_srwd_q;
    logic       finish;

    // instruction classification and guard evaluation
    always_comb begin
        is_mod   = (op == OPC_WRSR) || (op == OPC_PP) || (op == OPC_SE) || (op == OPC_BE);
        is_latch = (op == OPC_WREN) || (op == OPC_WRDI);
        is_ctrl  = is_mod || is_latch;
        bytes_ok = (edges_lo == 3'd0);
        unique case (op)
            OPC_WRSR:       guard_ok = !(srwd_q && !wp_n);
            OPC_PP, OPC_SE: guard_ok = !sector_locked;
            OPC_BE:         guard_ok = (bp_q == 3'd0);
            default:        guard_ok = 1'b1;
        endcase
        grant = cmd_valid && is_ctrl && (state_q == ST_IDLE) && !dpd &&
                (is_latch || (wel_q && bytes_ok && guard_ok));
        finish = (state_q == ST_BUSY) && op_done;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: if (boot_ready) state_d = ST_IDLE;
            ST_IDLE: if (grant && is_mod) state_d = ST_BUSY;
            ST_BUSY: if (op_done) state_d = ST_IDLE;
            default: state_d = ST_BOOT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // registered outputs and status bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept_q    <= 1'b0;
            reject_q    <= 1'b0;
            wel_q       <= 1'b0;
            bp_q        <= 3'd0;
            srwd_q      <= 1'b0;
            pend_wrsr_q <= 1'b0;
            pend_bp_q   <= 3'd0;
            pend_srwd_q <= 1'b0;
        end else begin
            accept_q <= grant;
            reject_q <= cmd_valid && is_ctrl && !grant;
            if (state_q == ST_BOOT) begin
                wel_q <= 1'b0;
            end else if (grant) begin
                if (op == OPC_WREN)      wel_q <= 1'b1;
                else if (op == OPC_WRDI) wel_q <= 1'b0;
                if (op == OPC_WRSR) begin
                    pend_wrsr_q <= 1'b1;
                    pend_bp_q   <= data[4:2];
                    pend_srwd_q <= data[7];
                end
            end else if (finish) begin
                wel_q       <= 1'b0;
                pend_wrsr_q <= 1'b0;
                if (pend_wrsr_q) begin
                    bp_q   <= pend_bp_q;
                    srwd_q <= pend_srwd_q;
                end
            end
        end
    end

    assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_q && reject_q));
    assert_boot_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT) |=> !wel_q);
    assert_need_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && is_mod && !wel_q) |=> !accept_q);
    assert_whole_bytes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && is_mod && (edges_lo != 3'd0)) |=> !accept_q);
    assert_bulk_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (op == OPC_BE) && (bp_q != 3'd0)) |=> !accept_q);
    assert_hw_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (op == OPC_WRSR) && srwd_q && !wp_n) |=> !accept_q);
    assert_sleep_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && dpd) |=> !accept_q);
    assert_busy_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (state_q == ST_BUSY)) |=> !accept_q);
    assert_reject_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reject_q && !$past(op_done)) |-> ($stable(wel_q) && $stable(bp_q) && $stable(srwd_q)));
    assert_stray_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !cmd_valid && (state_q == ST_IDLE)) |=> ($stable(wel_q) && $stable(bp_q)));
endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard
    import flash_wr_guard_pkg::*;
#(
    parameter int POWERUP_CYCLES = 1000,
    parameter int ADDR_W         = 24,
    parameter int SECTOR_LSB     = 16,
    parameter int SECTOR_BITS    = 6,
    parameter int EDGE_W         = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [EDGE_W-1:0] cmd_edges,
    input  logic [7:0]        cmd_data,
    input  logic              wp_n,
    input  logic              dpd,
    input  logic              op_done,
    output logic              cmd_accept,
    output logic              cmd_reject,
    output logic              wel,
    output logic [2:0]        bp,
    output logic              srwd
);
    logic                   boot_ready;
    logic                   sector_locked;
    logic [SECTOR_BITS-1:0] sector;

    assign sector = cmd_addr[SECTOR_LSB +: SECTOR_BITS];

    fwg_boot_timer #(.CYCLES(POWERUP_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (boot_ready)
    );

    fwg_sector_map #(.SECTOR_BITS(SECTOR_BITS)) u_map (
        .level  (bp),
        .sector (sector),
        .locked (sector_locked)
    );

    fwg_cmd_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .boot_ready    (boot_ready),
        .cmd_valid     (cmd_valid),
        .op            (opc_e'(cmd_op)),
        .edges_lo      (cmd_edges[2:0]),
        .data          (cmd_data),
        .sector_locked (sector_locked),
        .wp_n          (wp_n),
        .dpd           (dpd),
        .op_done       (op_done),
        .accept_q      (cmd_accept),
        .reject_q      (cmd_reject),
        .wel_q         (wel),
        .bp_q          (bp),
        .srwd_q        (srwd)
    );
endmodule

// File: tb/flash_wr_guard_tb_top.sv
module flash_wr_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PU         = 20;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cmd_valid = 0;
    logic [2:0]  cmd_op = 0;
    logic [23:0] cmd_addr = 0;
    logic [15:0] cmd_edges = 0;
    logic [7:0]  cmd_data = 0;
    logic        wp_n = 1;
    logic        dpd = 0;
    logic        op_done = 0;
    logic        cmd_accept, cmd_reject, wel, srwd;
    logic [2:0]  bp;

    int total = 0;
    int bad   = 0;

    localparam int NONE = 0, ACC = 1, REJ = 2;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_wr_guard #(.POWERUP_CYCLES(PU)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_edges(cmd_edges), .cmd_data(cmd_data),
        .wp_n(wp_n), .dpd(dpd), .op_done(op_done), .cmd_accept(cmd_accept),
        .cmd_reject(cmd_reject), .wel(wel), .bp(bp), .srwd(srwd)
    );

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [23:0] a, input int e,
                         input logic [7:0] d, input int exp_res, input string tag);
        int got;
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_edges = 16'(e); cmd_data = d;
        @(negedge clk);
        cmd_valid = 0;
        got = cmd_accept ? ACC : (cmd_reject ? REJ : NONE);
        if (cmd_accept && cmd_reject) got = 3;
        chk(got, exp_res, tag);
    endtask

    task automatic complete();
        @(negedge clk); op_done = 1;
        @(negedge clk); op_done = 0;
    endtask

    task automatic chk_bits(input int w, input int b, input int s, input string tag);
        chk(int'(wel), w, {tag, " wel"});
        chk(int'(bp), b, {tag, " bp"});
        chk(int'(srwd), s, {tag, " srwd"});
    endtask

    task automatic set_prot(input int b, input int s);
        issue(3'd1, 0, 8, 0, ACC, "R2 set latch");
        issue(3'd3, 0, 16, {s[0], 2'b00, b[2:0], 2'b00}, ACC, "R9 status write");
        complete();
        chk_bits(0, b, s, "R9 status applied");
    endtask

    task automatic t_boot();
        chk_bits(0, 0, 0, "R1 reset");
        issue(3'd1, 0, 8, 0, REJ, "R1 lockout reject");
        chk(int'(wel), 0, "R1 latch held");
        repeat (PU + 5) @(negedge clk);
    endtask

    task automatic t_latch();
        issue(3'd1, 0, 8, 0, ACC, "R2 set");
        chk(int'(wel), 1, "R2 set wel");
        issue(3'd2, 0, 8, 0, ACC, "R2 clear");
        chk(int'(wel), 0, "R2 clear wel");
        issue(3'd7, 0, 40, 0, NONE, "R11 read silent");
        issue(3'd0, 0, 8, 0, NONE, "R11 none silent");
    endtask

    task automatic t_no_latch();
        issue(3'd4, 0, 40, 0, REJ, "R3 program");
        issue(3'd5, 0, 32, 0, REJ, "R3 sector erase");
        issue(3'd6, 0, 8, 0, REJ, "R3 bulk erase");
        issue(3'd3, 0, 16, 8'h1c, REJ, "R3 status write");
        chk_bits(0, 0, 0, "R10 after R3");
    endtask

    task automatic t_bytes();
        issue(3'd1, 0, 9, 0, ACC, "R4 latch exempt");
        issue(3'd4, 0, 37, 0, REJ, "R4 program odd");
        issue(3'd5, 0, 33, 0, REJ, "R4 erase odd");
        chk(int'(wel), 1, "R10 latch kept");
        issue(3'd4, 0, 40, 0, ACC, "R4 program whole");
        issue(3'd1, 0, 8, 0, REJ, "R9 busy reject");
        complete();
        chk(int'(wel), 0, "R9 done clears latch");
    endtask

    task automatic t_map();
        for (int b = 0; b < 8; b++) begin
            int cnt, edge_s;
            set_prot(b, 0);
            cnt = (b == 0) ? 0 : (64 >> (7 - b));
            edge_s = 64 - cnt;
            if (edge_s > 0) begin
                issue(3'd1, 0, 8, 0, ACC, "R5 latch");
                issue(3'd5, {2'b11, 6'(edge_s - 1), 16'h0}, 32, 0, ACC, "R5 below edge");
                complete();
            end
            if (edge_s < 64) begin
                issue(3'd1, 0, 8, 0, ACC, "R5 latch");
                issue(3'd4, {2'b00, 6'(edge_s), 16'h12}, 24, 0, REJ, "R5 at edge");
                issue(3'd2, 0, 8, 0, ACC, "R2 clear");
            end
        end
        set_prot(0, 0);
    endtask

    task automatic t_bulk();
        set_prot(1, 0);
        issue(3'd1, 0, 8, 0, ACC, "R6 latch");
        issue(3'd6, 0, 8, 0, REJ, "R6 level set");
        chk(int'(wel), 1, "R10 latch kept");
        issue(3'd2, 0, 8, 0, ACC, "R2 clear");
        set_prot(0, 0);
        issue(3'd1, 0, 8, 0, ACC, "R6 latch");
        issue(3'd6, 0, 8, 0, ACC, "R6 level zero");
        complete();
    endtask

    task automatic t_lock();
        set_prot(2, 1);
        wp_n = 0;
        issue(3'd1, 0, 8, 0, ACC, "R7 latch");
        issue(3'd3, 0, 16, 8'h00, REJ, "R7 locked");
        chk_bits(1, 2, 1, "R10 locked bits");
        wp_n = 1;
        issue(3'd3, 0, 16, 8'h00, ACC, "R7 pin high");
        complete();
        chk_bits(0, 0, 0, "R9 unlocked");
    endtask

    task automatic t_sleep();
        issue(3'd1, 0, 8, 0, ACC, "R8 latch");
        dpd = 1;
        issue(3'd4, 0, 40, 0, REJ, "R8 program");
        issue(3'd2, 0, 8, 0, REJ, "R8 clear latch");
        chk(int'(wel), 1, "R8 latch kept");
        dpd = 0;
        issue(3'd2, 0, 8, 0, ACC, "R8 awake clear");
    endtask

    task automatic t_collide();
        int got;
        issue(3'd1, 0, 8, 0, ACC, "R9 latch");
        issue(3'd5, 0, 32, 0, ACC, "R9 erase");
        @(negedge clk);
        op_done = 1; cmd_valid = 1; cmd_op = 3'd1;
        @(negedge clk);
        op_done = 0; cmd_valid = 0;
        got = cmd_accept ? ACC : (cmd_reject ? REJ : NONE);
        chk(got, REJ, "R9 same-cycle instruction");
        chk(int'(wel), 0, "R9 same-cycle completion");
        issue(3'd1, 0, 8, 0, ACC, "R9 idle again");
    endtask

    task automatic t_stray();
        complete();
        chk_bits(1, 0, 0, "R12 stray completion");
        issue(3'd2, 0, 8, 0, ACC, "R2 clear");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_boot();
        t_latch();
        t_no_latch();
        t_bytes();
        t_map();
        t_bulk();
        t_lock();
        t_sleep();
        t_collide();
        t_stray();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule